// File: doc/BRIEF.md
# Drive Attention and Interrupt Request Controller

This block sits inside a disk controller. It gathers attention events from up to eight drives into a summary word and folds controller events into a small set of status flags. The controller events are a transfer error reported by a drive, an error on the control bus, the end of a transfer and the start of a transfer. From these it drives one interrupt request line. The request line carries a configured priority level. When the processor acknowledges the request, the block withdraws it and returns a configured vector for one cycle.

A drive pulses `attn_set` or `attn_clr` with its number on `attn_drive`. The controller's register block supplies the clear strobes, the interrupt-enable write and the control-bus-error event. The priority level and the vector are static configuration inputs. If either one is outside its legal range, no request is ever raised.

Top module: `attn_irq_ctl`

## Requirements
- R1: A pulse on `attn_set` sets bit `attn_drive` (bit n for drive n, drive 0 at bit 0) of `attn_summary` and sets `flag_sc` on the next clock edge. If `attn_clr` arrives in the same cycle, the set wins.
- R2: `attn_set` raises `irq_req` when `flag_ie` is 1, including when that drive's bit is already set. It does not raise `irq_req` when `flag_ie` is 0.
- R3: `attn_clr` removes bit `attn_drive` from the summary. `flag_sc` falls only when this makes the whole summary zero. Clearing a bit that is not set changes nothing.
- R4: When `flag_sc` falls because the summary emptied, a pending request is withdrawn unless `flag_tre` or `flag_cbe` is still 1.
- R5: `drive_err` sets `flag_tre`, ends the transfer by setting `flag_rdy`, and raises a request whatever the value of `flag_ie`.
- R6: `xfer_done` sets `flag_rdy` and raises a request whatever the value of `flag_ie`. `xfer_start` clears `flag_rdy`.
- R7: `cbe_set` sets `flag_cbe` and raises a request only when `flag_ie` is 1.
- R8: `irq_ack` while `irq_req` is 1 drops `irq_req` on the next edge. In that same cycle it pulses `vec_valid` high for one cycle with `vec_out` equal to `cfg_vector`. `irq_ack` without a pending request leaves `vec_valid` at 0.
- R9: A request is raised only if `cfg_level` is 4 to 7 and `cfg_vector` is a multiple of 4 between 4 and 256 inclusive. `irq_level` shows `cfg_level` while `irq_req` is 1 and shows 0 otherwise.
- R10: `ctl_clear` sets `flag_rdy` to 1, clears `flag_sc`, `flag_tre`, `flag_cbe` and `flag_ie`, drops `irq_req`, and keeps `attn_summary`. Reset gives the same state and also clears `attn_summary`.
- R11: `ie_wr` loads `ie_val` into `flag_ie`. `tre_clr` clears `flag_tre`, except that a `drive_err` in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 3 | Static interrupt priority level |
| cfg_vector | input | 9 | Static interrupt vector |
| attn_set | input | 1 | Drive asserts attention (pulse) |
| attn_clr | input | 1 | Drive withdraws attention (pulse) |
| attn_drive | input | 3 | Drive number for attention pulses |
| drive_err | input | 1 | Drive transfer error (pulse) |
| xfer_start | input | 1 | Transfer begins, clears ready (pulse) |
| xfer_done | input | 1 | Transfer finished (pulse) |
| tre_clr | input | 1 | Clear transfer-error flag (pulse) |
| cbe_set | input | 1 | Control-bus error event (pulse) |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_val | input | 1 | Interrupt-enable value written |
| ctl_clear | input | 1 | Controller clear strobe |
| irq_ack | input | 1 | Interrupt acknowledge |
| attn_summary | output | 8 | Per-drive attention summary |
| flag_sc | output | 1 | Special condition |
| flag_tre | output | 1 | Transfer error |
| flag_cbe | output | 1 | Control-bus error |
| flag_rdy | output | 1 | Ready |
| flag_ie | output | 1 | Interrupt enable |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level presented with the request |
| vec_valid | output | 1 | Vector return strobe |
| vec_out | output | 9 | Returned vector |

## Verification
The assertions check the following on every cycle:
- the summary bit and the special-condition flag after each attention set;
- that special condition falls only when the summary is empty;
- that the request falls only through acknowledge, controller clear or a special-condition drop with no error flag left;
- the error and completion flags;
- the vector returned on an acknowledge;
- that a request never rises under an illegal configuration.

Some behaviours need the bench's scenarios:
- the re-raise on an attention bit that is already set;
- survival of a request across a special-condition drop while control-bus error is held;
- precedence of drive error over a transfer-error clear;
- the boundary configurations 4, 256 and 260;
- retention of the summary across controller clear.

// File: rtl/attn_irq_pkg.sv
package attn_irq_pkg;

    localparam int unsigned LVL_MIN   = 4;
    localparam int unsigned LVL_MAX   = 7;
    localparam int unsigned VEC_MIN   = 4;
    localparam int unsigned VEC_MAX   = 256;
    localparam int unsigned VEC_ALIGN = 4;

    typedef struct packed {
        logic tre;
        logic cbe;
        logic rdy;
        logic ie;
    } ctl_flags_t;

    function automatic logic cfg_valid(input int unsigned lvl, input int unsigned vec);
        return (lvl >= LVL_MIN) && (lvl <= LVL_MAX) &&
               ((vec % VEC_ALIGN) == 0) && (vec >= VEC_MIN) && (vec <= VEC_MAX);
    endfunction

endpackage

// File: rtl/attn_summary.sv
module attn_summary #(
    parameter int NUM_DRV = 8,
    localparam int DRV_W  = $clog2(NUM_DRV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_clear,
    input  logic               attn_set,
    input  logic               attn_clr,
    input  logic [DRV_W-1:0]   attn_drive,
    output logic [NUM_DRV-1:0] summary,
    output logic               sc,
    output logic               sc_drop
);

    logic [NUM_DRV-1:0] sum_q, sum_n;
    logic               sc_q, sc_n;
    logic               hit_clr;

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_bit
        logic sel;
        assign sel      = (attn_drive == DRV_W'(g));
        assign sum_n[g] = (attn_set & sel) | (sum_q[g] & ~(attn_clr & sel));
    end

    // a clear only counts when it removes a bit that was set
    assign hit_clr = attn_clr & sum_q[attn_drive];

    always_comb begin
        sc_n    = sc_q;
        sc_drop = 1'b0;
        if (ctl_clear) begin
            sc_n = 1'b0;
        end else if (attn_set) begin
            sc_n = 1'b1;
        end else if (hit_clr && (sum_n == '0) && sc_q) begin
            sc_n    = 1'b0;
            sc_drop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            sc_q  <= 1'b0;
        end else begin
            sum_q <= sum_n;
            sc_q  <= sc_n;
        end
    end

    assign summary = sum_q;
    assign sc      = sc_q;

endmodule

// File: rtl/status_flags.sv
module status_flags
    import attn_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_clear,
    input  logic       drive_err,
    input  logic       xfer_start,
    input  logic       xfer_done,
    input  logic       tre_clr,
    input  logic       cbe_set,
    input  logic       ie_wr,
    input  logic       ie_val,
    output ctl_flags_t flags,
    output logic       err_held_n
);

    ctl_flags_t q, n;

    always_comb begin
        n = q;
        if (ctl_clear) begin
            n = '{tre: 1'b0, cbe: 1'b0, rdy: 1'b1, ie: 1'b0};
        end else begin
            if (drive_err)    n.tre = 1'b1;
            else if (tre_clr) n.tre = 1'b0;
            if (cbe_set)      n.cbe = 1'b1;
            if (drive_err || xfer_done) n.rdy = 1'b1;
            else if (xfer_start)        n.rdy = 1'b0;
            if (ie_wr)        n.ie  = ie_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{tre: 1'b0, cbe: 1'b0, rdy: 1'b1, ie: 1'b0};
        else     q <= n;
    end

    assign flags      = q;
    assign err_held_n = n.tre | n.cbe;

endmodule

// File: rtl/irq_request.sv
module irq_request #(
    parameter int LVL_W = 3,
    parameter int VEC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_clear,
    input  logic             raise,
    input  logic             drop,
    input  logic             irq_ack,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic [VEC_W-1:0] cfg_vector,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    logic             req_q;
    logic             vv_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            vv_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            if (ctl_clear)           req_q <= 1'b0;
            else if (raise)          req_q <= 1'b1;
            else if (irq_ack | drop) req_q <= 1'b0;
            vv_q  <= irq_ack & req_q;
            vec_q <= (irq_ack & req_q) ? cfg_vector : '0;
        end
    end

    assign irq_req   = req_q;
    assign irq_level = req_q ? cfg_level : '0;
    assign vec_valid = vv_q;
    assign vec_out   = vec_q;

endmodule

// File: rtl/attn_irq_ctl.sv
module attn_irq_ctl
    import attn_irq_pkg::*;
#(
    parameter int NUM_DRV = 8,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 9,
    localparam int DRV_W  = $clog2(NUM_DRV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   cfg_level,
    input  logic [VEC_W-1:0]   cfg_vector,
    input  logic               attn_set,
    input  logic               attn_clr,
    input  logic [DRV_W-1:0]   attn_drive,
    input  logic               drive_err,
    input  logic               xfer_start,
    input  logic               xfer_done,
    input  logic               tre_clr,
    input  logic               cbe_set,
    input  logic               ie_wr,
    input  logic               ie_val,
    input  logic               ctl_clear,
    input  logic               irq_ack,
    output logic [NUM_DRV-1:0] attn_summary,
    output logic               flag_sc,
    output logic               flag_tre,
    output logic               flag_cbe,
    output logic               flag_rdy,
    output logic               flag_ie,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_level,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);

    ctl_flags_t flags;
    logic       sc_drop, err_held_n;
    logic       cfg_ok, raise, drop;

    attn_summary #(.NUM_DRV(NUM_DRV)) u_attn (
        .clk, .rst, .ctl_clear, .attn_set, .attn_clr, .attn_drive,
        .summary(attn_summary), .sc(flag_sc), .sc_drop(sc_drop)
    );

    status_flags u_flags (
        .clk, .rst, .ctl_clear, .drive_err, .xfer_start, .xfer_done,
        .tre_clr, .cbe_set, .ie_wr, .ie_val,
        .flags(flags), .err_held_n(err_held_n)
    );

    assign cfg_ok = cfg_valid(32'(cfg_level), 32'(cfg_vector));

    // attention and bus error honour enable; error and completion end the
    // transfer and always request
    assign raise = cfg_ok & ((flags.ie & (attn_set | cbe_set)) | drive_err | xfer_done);
    assign drop  = sc_drop & ~err_held_n;

    irq_request #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_irq (
        .clk, .rst, .ctl_clear, .raise(raise), .drop(drop), .irq_ack,
        .cfg_level, .cfg_vector, .irq_req, .irq_level, .vec_valid, .vec_out
    );

    assign flag_tre = flags.tre;
    assign flag_cbe = flags.cbe;
    assign flag_rdy = flags.rdy;
    assign flag_ie  = flags.ie;

endmodule

// File: rtl/attn_irq_chk.sv
module attn_irq_chk
    import attn_irq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cfg_level,
    input logic [8:0] cfg_vector,
    input logic       attn_set,
    input logic [2:0] attn_drive,
    input logic       drive_err,
    input logic       xfer_done,
    input logic       cbe_set,
    input logic       ctl_clear,
    input logic       irq_ack,
    input logic [7:0] attn_summary,
    input logic       flag_sc,
    input logic       flag_tre,
    input logic       flag_cbe,
    input logic       flag_rdy,
    input logic       flag_ie,
    input logic       irq_req,
    input logic       vec_valid,
    input logic [8:0] vec_out
);

    logic ok;
    assign ok = cfg_valid(32'(cfg_level), 32'(cfg_vector));

    p_attn_set_r1: assert property (@(posedge clk) disable iff (rst)
        attn_set && !ctl_clear |=> flag_sc && attn_summary[$past(attn_drive)]);

    p_attn_raise_r2: assert property (@(posedge clk) disable iff (rst)
        attn_set && flag_ie && !ctl_clear && ok |=> irq_req);

    p_sc_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_sc) |-> (attn_summary == 8'h00) || $past(ctl_clear) || $past(rst));

    p_req_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_req) |-> $past(irq_ack) || $past(ctl_clear) || $past(rst) ||
                           (!flag_tre && !flag_cbe && $fell(flag_sc)));

    p_drive_err_r5: assert property (@(posedge clk) disable iff (rst)
        drive_err && !ctl_clear |=> flag_tre && flag_rdy);

    p_done_ready_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> flag_rdy);

    p_cbe_r7: assert property (@(posedge clk) disable iff (rst)
        cbe_set && !ctl_clear |=> flag_cbe);

    p_ack_vector_r8: assert property (@(posedge clk) disable iff (rst)
        irq_ack && irq_req |=> vec_valid && (vec_out == $past(cfg_vector)));

    p_no_vector_r8: assert property (@(posedge clk) disable iff (rst)
        !(irq_ack && irq_req) |=> !vec_valid);

    p_cfg_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(ok));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_clear |=> flag_rdy && !flag_sc && !flag_tre && !flag_cbe && !flag_ie && !irq_req);

endmodule

bind attn_irq_ctl attn_irq_chk i_attn_irq_chk (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
    .attn_set(attn_set), .attn_drive(attn_drive), .drive_err(drive_err),
    .xfer_done(xfer_done), .cbe_set(cbe_set), .ctl_clear(ctl_clear),
    .irq_ack(irq_ack), .attn_summary(attn_summary), .flag_sc(flag_sc),
    .flag_tre(flag_tre), .flag_cbe(flag_cbe), .flag_rdy(flag_rdy),
    .flag_ie(flag_ie), .irq_req(irq_req), .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/test_attn_irq_ctl.sv
module test_attn_irq_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_level = 3'd5;
    logic [8:0] cfg_vector = 9'd84;
    logic       attn_set = 0, attn_clr = 0, drive_err = 0, xfer_start = 0, xfer_done = 0;
    logic       tre_clr = 0, cbe_set = 0, ie_wr = 0, ie_val = 0, ctl_clear = 0, irq_ack = 0;
    logic [2:0] attn_drive = '0;
    logic [7:0] attn_summary;
    logic       flag_sc, flag_tre, flag_cbe, flag_rdy, flag_ie, irq_req, vec_valid;
    logic [2:0] irq_level;
    logic [8:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    attn_irq_ctl i_attn_irq_ctl (
        .clk, .rst, .cfg_level, .cfg_vector, .attn_set, .attn_clr, .attn_drive,
        .drive_err, .xfer_start, .xfer_done, .tre_clr, .cbe_set, .ie_wr, .ie_val,
        .ctl_clear, .irq_ack, .attn_summary, .flag_sc, .flag_tre, .flag_cbe,
        .flag_rdy, .flag_ie, .irq_req, .irq_level, .vec_valid, .vec_out
    );

    // behavioural reference, advanced on every rising edge
    int m_sum = 0, m_sc = 0, m_tre = 0, m_cbe = 0, m_rdy = 1, m_ie = 0, m_req = 0, m_vv = 0, m_vec = 0;

    function automatic int legal(int lvl, int vec);
        return (lvl >= 4 && lvl <= 7 && vec % 4 == 0 && vec >= 4 && vec <= 256) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int smask, cmask, nsum, nsc, ntre, ncbe, nrdy, nie, nreq, raise, drop;
        if (rst) begin
            m_sum = 0; m_sc = 0; m_tre = 0; m_cbe = 0; m_rdy = 1;
            m_ie = 0; m_req = 0; m_vv = 0; m_vec = 0;
        end else begin
            smask = attn_set ? (1 << attn_drive) : 0;
            cmask = attn_clr ? (1 << attn_drive) : 0;
            nsum  = (m_sum & ~cmask) | smask;
            raise = legal(cfg_level, cfg_vector) &&
                    ((m_ie && (attn_set || cbe_set)) || drive_err || xfer_done);
            if (ctl_clear) begin
                nsc = 0; ntre = 0; ncbe = 0; nrdy = 1; nie = 0;
            end else begin
                nsc  = attn_set ? 1 : ((attn_clr && (m_sum & cmask) != 0 && nsum == 0) ? 0 : m_sc);
                ntre = drive_err ? 1 : (tre_clr ? 0 : m_tre);
                ncbe = cbe_set ? 1 : m_cbe;
                nrdy = (drive_err || xfer_done) ? 1 : (xfer_start ? 0 : m_rdy);
                nie  = ie_wr ? int'(ie_val) : m_ie;
            end
            drop = (m_sc && !nsc && !ctl_clear && !ntre && !ncbe) ? 1 : 0;
            nreq = ctl_clear ? 0 : (raise ? 1 : ((irq_ack || drop) ? 0 : m_req));
            m_vv  = (irq_ack && m_req) ? 1 : 0;
            m_vec = m_vv ? int'(cfg_vector) : 0;
            m_sum = nsum; m_sc = nsc; m_tre = ntre; m_cbe = ncbe;
            m_rdy = nrdy; m_ie = nie; m_req = nreq;
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cmp("R1", "summary", attn_summary, m_sum);
        cmp("R3", "sc", flag_sc, m_sc);
        cmp("R5", "tre", flag_tre, m_tre);
        cmp("R7", "cbe", flag_cbe, m_cbe);
        cmp("R6", "rdy", flag_rdy, m_rdy);
        cmp("R11", "ie", flag_ie, m_ie);
        cmp("R2", "req", irq_req, m_req);
        cmp("R9", "level", irq_level, m_req ? int'(cfg_level) : 0);
        cmp("R8", "vec_valid", vec_valid, m_vv);
        cmp("R8", "vec_out", vec_out, m_vec);
    end

    task automatic step();
        @(negedge clk);
        attn_set = 0; attn_clr = 0; drive_err = 0; xfer_start = 0; xfer_done = 0;
        tre_clr = 0; cbe_set = 0; ie_wr = 0; ctl_clear = 0; irq_ack = 0;
    endtask

    task automatic attn(bit set, int drv);
        attn_drive = 3'(drv);
        if (set) attn_set = 1; else attn_clr = 1;
        step();
    endtask

    task automatic ack();
        irq_ack = 1; step();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        cmp("R10", "reset rdy", flag_rdy, 1);
        cmp("R10", "reset req", irq_req, 0);

        attn(1, 3);
        cmp("R1", "summary drive3", attn_summary, 8);
        cmp("R2", "no req with ie off", irq_req, 0);

        ie_wr = 1; ie_val = 1; step();
        cmp("R11", "ie loaded", flag_ie, 1);

        attn(1, 3);
        cmp("R2", "re-raise on set bit", irq_req, 1);
        cmp("R9", "level shown", irq_level, 5);

        ack();
        cmp("R8", "req withdrawn", irq_req, 0);
        cmp("R8", "vector", vec_out, 84);
        step();
        cmp("R8", "vec strobe one cycle", vec_valid, 0);

        attn(1, 5);
        attn(0, 3);
        cmp("R3", "sc held while bits remain", flag_sc, 1);
        cmp("R3", "summary drive5 only", attn_summary, 32);
        attn(0, 5);
        cmp("R3", "sc falls at empty", flag_sc, 0);
        cmp("R4", "req dropped with sc", irq_req, 0);
        attn(0, 2);
        cmp("R3", "clear of unset bit", attn_summary, 0);

        cbe_set = 1; step();
        cmp("R7", "cbe raises", irq_req, 1);
        ack();
        attn(1, 1);
        attn(0, 1);
        cmp("R4", "req survives on cbe", irq_req, 1);
        ack();

        attn(1, 0);
        ctl_clear = 1; step();
        cmp("R10", "summary kept", attn_summary, 1);
        cmp("R10", "req cleared", irq_req, 0);
        cmp("R10", "ie cleared", flag_ie, 0);

        cbe_set = 1; step();
        cmp("R7", "cbe no req with ie off", irq_req, 0);
        ctl_clear = 1; step();

        xfer_start = 1; step();
        cmp("R6", "start clears rdy", flag_rdy, 0);
        xfer_done = 1; step();
        cmp("R6", "done sets rdy", flag_rdy, 1);
        cmp("R6", "done requests", irq_req, 1);
        ack();

        xfer_start = 1; step();
        drive_err = 1; step();
        cmp("R5", "tre set", flag_tre, 1);
        cmp("R5", "err ends transfer", flag_rdy, 1);
        cmp("R5", "err requests", irq_req, 1);
        ack();
        drive_err = 1; tre_clr = 1; step();
        cmp("R11", "err beats tre_clr", flag_tre, 1);
        tre_clr = 1; step();
        cmp("R11", "tre_clr", flag_tre, 0);
        ack();
        cmp("R8", "no pending req", irq_req, 0);
        ack();
        cmp("R8", "ack without req", vec_valid, 0);

        begin
            int cases[7][3] = '{'{3, 84, 0}, '{7, 84, 1}, '{5, 6, 0}, '{5, 0, 0},
                                '{5, 4, 1}, '{5, 256, 1}, '{5, 260, 0}};
            for (int i = 0; i < 7; i++) begin
                rst = 1;
                cfg_level = 3'(cases[i][0]);
                cfg_vector = 9'(cases[i][1]);
                step(); step();
                rst = 0;
                step();
                cmp("R10", "reset clears summary", attn_summary, 0);
                xfer_done = 1; step();
                cmp("R9", "config gate", irq_req, cases[i][2]);
            end
        end

        step();
        summary();
    end

endmodule